// File: doc/BRIEF.md
# Per-CPU Interval Ignore Counter

This block keeps one down-counter per processor that lets software skip a chosen number of periodic timer ticks before that processor is interrupted. Every rising edge of the shared tick input decrements each present processor's counter by one. When a counter passes below zero it wraps around and sets a sticky overflow flag at bit 24. The count keeps decrementing after that, so software can read the register and work out how many ticks went by after the ignore window ended.

While a processor's overflow flag is set, every tick raises a one-cycle timer-set pulse for that processor and drives its timer interrupt line high. The line stays high until software writes that processor's register. A write loads a fresh 24-bit count and clears the overflow flag. Software reads and writes the four registers through a simple strobe-based CSR port. Processors whose present bit is low are frozen: their counters do not move and they raise no pulse or interrupt.

Top module: `iic_bank`

## Requirements
- R1: After reset every counter reads 0 with the overflow bit (bit 24) clear. All timer_set and timer_irq outputs are low.
- R2: A write stores csr_wdata[23:0] as the count and clears bit 24. A read returns the 25-bit register, zero-extended, on csr_rdata one cycle after the csr_rd strobe. csr_rdata holds that value until the next read.
- R3: The register for CPU 0 is at offset 0x380, CPU 1 at 0x3C0, CPU 2 at 0x700 and CPU 3 at 0x740.
- R4: Each low-to-high transition of tick_in decrements every present counter by exactly one, however long tick_in stays high. A high-to-low transition changes nothing.
- R5: A tick on a count of zero wraps the count to 0xFFFFFF and sets bit 24.
- R6: Once set, bit 24 stays set through further ticks and the count keeps decrementing. Only a write to that register clears it.
- R7: Each tick that leaves bit 24 set gives exactly one single-cycle pulse on that CPU's timer_set bit.
- R8: timer_irq for a CPU goes high with its first pulse and stays high until a write to that CPU's register.
- R9: A CPU whose cpu_present bit is low keeps its register value across ticks and raises neither timer_set nor timer_irq.
- R10: When a write to a register and a tick update fall in the same clock cycle, the written value is stored and that tick is lost for that CPU only.
- R11: A read of any other offset returns 0. A write to any other offset changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Asynchronous periodic tick, rising edge counts |
| cpu_present | input | NUM_CPU | One enable bit per processor |
| csr_wr | input | 1 | Write strobe |
| csr_rd | input | 1 | Read strobe |
| csr_addr | input | AW | Register offset |
| csr_wdata | input | DW | Write data |
| csr_rdata | output | DW | Registered read data |
| timer_set | output | NUM_CPU | Per-CPU one-cycle timer pending set pulse |
| timer_irq | output | NUM_CPU | Per-CPU timer interrupt level |

## Verification
The bench builds the block with its default parameters: four CPUs, a 24-bit count, 12-bit offsets and a two-stage synchroniser. It drives CPU 2 as absent. Small loaded counts bring the zero wrap and the sticky overflow within a few ticks. A write of all ones checks the 24-bit mask, and a decrement from there checks the upper count bits. The two-stage synchroniser fixes the update at the third clock after tick_in rises. The bench uses that fixed latency to land a write on the same cycle as a tick update.

// File: rtl/iic_pkg.sv
package iic_pkg;

  localparam int unsigned SLOT_STRIDE = 16'h040;

  // Offsets of the per-CPU registers: two in a low bank, two in a high bank.
  function automatic logic [15:0] slot_offset(input int unsigned idx);
    logic [15:0] base;
    base = (idx < 2) ? 16'h0380 : 16'h0700;
    return base + 16'(SLOT_STRIDE * (idx % 2));
  endfunction

endpackage

// File: rtl/iic_tick_edge.sv
module iic_tick_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  output logic tick_rise
);
  localparam int unsigned SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SH_W-2:0], tick_in};
  end

  assign tick_rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

  // R4
  single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    tick_rise |=> !tick_rise);

endmodule

// File: rtl/iic_decode.sv
module iic_decode
  import iic_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned AW      = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      addr,
  output logic [NUM_CPU-1:0] sel,
  output logic               hit
);
  for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
    localparam logic [AW-1:0] OFS = AW'(slot_offset(g));
    assign sel[g] = (addr == OFS);
  end

  assign hit = |sel;

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

endmodule

// File: rtl/iic_counter.sv
module iic_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           present,
  input  logic           tick,
  input  logic           wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W:0] value,
  output logic           set_pulse,
  output logic           irq
);
  localparam int unsigned REG_W = CNT_W + 1;

  logic [REG_W-1:0] dec;
  logic [REG_W-1:0] nxt;
  logic             do_tick;

  always_comb begin
    dec     = value - 1'b1;
    nxt     = {value[CNT_W] | dec[CNT_W], dec[CNT_W-1:0]};
    do_tick = tick & present & ~wr_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value     <= '0;
      set_pulse <= 1'b0;
      irq       <= 1'b0;
    end else if (wr_en) begin
      value     <= {1'b0, wr_data};
      set_pulse <= 1'b0;
      irq       <= 1'b0;
    end else if (do_tick) begin
      value     <= nxt;
      set_pulse <= nxt[CNT_W];
      irq       <= irq | nxt[CNT_W];
    end else begin
      set_pulse <= 1'b0;
    end
  end

  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (value == {1'b0, $past(wr_data)}));
  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (do_tick && value[CNT_W-1:0] == '0) |=> (value == {REG_W{1'b1}}));
  // R6
  ov_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (value[CNT_W] && !wr_en) |=> value[CNT_W]);
  // R7
  pulse_needs_ov_chk: assert property (@(posedge clk) disable iff (rst)
    set_pulse |-> value[CNT_W]);
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !wr_en) |=> irq);
  // R9
  absent_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!present && !wr_en) |=> ($stable(value) && !set_pulse));

endmodule

// File: rtl/iic_bank.sv
module iic_bank #(
  parameter int unsigned NUM_CPU     = 4,
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned AW          = 12,
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_in,
  input  logic [NUM_CPU-1:0] cpu_present,
  input  logic               csr_wr,
  input  logic               csr_rd,
  input  logic [AW-1:0]      csr_addr,
  input  logic [DW-1:0]      csr_wdata,
  output logic [DW-1:0]      csr_rdata,
  output logic [NUM_CPU-1:0] timer_set,
  output logic [NUM_CPU-1:0] timer_irq
);
  localparam int unsigned REG_W = CNT_W + 1;

  logic                          tick_rise;
  logic [NUM_CPU-1:0]            sel;
  logic                          hit;
  logic [NUM_CPU-1:0][REG_W-1:0] vals;
  logic [DW-1:0]                 rd_mux;

  iic_tick_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .tick_in(tick_in), .tick_rise(tick_rise)
  );

  iic_decode #(.NUM_CPU(NUM_CPU), .AW(AW)) u_dec (
    .clk(clk), .rst(rst), .addr(csr_addr), .sel(sel), .hit(hit)
  );

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    iic_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .present  (cpu_present[g]),
      .tick     (tick_rise),
      .wr_en    (csr_wr & sel[g]),
      .wr_data  (csr_wdata[CNT_W-1:0]),
      .value    (vals[g]),
      .set_pulse(timer_set[g]),
      .irq      (timer_irq[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (sel[i]) rd_mux = rd_mux | DW'(vals[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         csr_rdata <= '0;
    else if (csr_rd) csr_rdata <= rd_mux;
  end

  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_rd && !hit) |=> (csr_rdata == '0));
  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !csr_rd |=> $stable(csr_rdata));

endmodule

// File: tb/tb_iic_bank.sv
`timescale 1ns/1ps
module tb_iic_bank;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_in = 1'b0;
  logic [NC-1:0] cpu_present = 4'b1011;
  logic          csr_wr = 1'b0;
  logic          csr_rd = 1'b0;
  logic [11:0]   csr_addr = '0;
  logic [31:0]   csr_wdata = '0;
  logic [31:0]   csr_rdata;
  logic [NC-1:0] timer_set;
  logic [NC-1:0] timer_irq;

  always #2.5 clk = ~clk;

  iic_bank dut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .cpu_present(cpu_present),
    .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .timer_set(timer_set), .timer_irq(timer_irq)
  );

  int checks = 0;
  int errors = 0;

  logic [11:0] ofs [NC] = '{12'h380, 12'h3C0, 12'h700, 12'h740};
  logic [24:0] mdl [NC];
  int          exp_pulse [NC];
  logic        exp_irq [NC];
  int          pulse_cnt [NC];

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_d = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares read data one cycle after each read strobe.
  always @(posedge clk) rd_d <= csr_rd;
  always @(negedge clk) begin
    for (int i = 0; i < NC; i++) if (!rst && timer_set[i]) pulse_cnt[i]++;
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 actual unexpected-read expected none");
      end else begin
        check(tag_q.pop_front(), csr_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic do_read(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    csr_rd = 1'b1; csr_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    csr_rd = 1'b0;
  endtask

  task automatic do_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic wr_cpu(int i, logic [31:0] d);
    do_write(ofs[i], d);
    mdl[i] = {1'b0, d[23:0]};
    exp_irq[i] = 1'b0;
  endtask

  function automatic void model_tick(int skip);
    for (int i = 0; i < NC; i++) begin
      if (cpu_present[i] && i != skip) begin
        mdl[i] = ((mdl[i] - 25'd1) & 25'h1FFFFFF) | (mdl[i] & 25'h1000000);
        if (mdl[i][24]) begin
          exp_pulse[i]++;
          exp_irq[i] = 1'b1;
        end
      end
    end
  endfunction

  task automatic do_tick(int hold);
    @(negedge clk);
    tick_in = 1'b1;
    repeat (hold) @(negedge clk);
    tick_in = 1'b0;
    repeat (6) @(negedge clk);
    model_tick(-1);
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < NC; i++) do_read(ofs[i], {7'd0, mdl[i]}, tag);
    repeat (2) @(negedge clk);
    for (int i = 0; i < NC; i++) begin
      check({tag, " R7 pulses"}, pulse_cnt[i], exp_pulse[i]);
      check({tag, " R8 irq"}, {31'd0, timer_irq[i]}, {31'd0, exp_irq[i]});
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin
      mdl[i] = '0; exp_pulse[i] = 0; exp_irq[i] = 1'b0; pulse_cnt[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 set", {28'd0, timer_set}, 32'd0);
    check_all("R1 reset");

    // R2 R3 loads with masking, per-offset mapping
    wr_cpu(0, 32'd3);
    wr_cpu(1, 32'hFFFF_FFFF);
    wr_cpu(2, 32'd5);
    wr_cpu(3, 32'h7F00_0001);
    check_all("R2 R3 load");

    // R11 unmapped write and read
    do_write(12'h400, 32'd9);
    do_read(12'h400, 32'd0, "R11 unmapped read");
    do_write(12'h384, 32'd9);
    check_all("R11 no side effect");

    // R4 R9 single tick, CPU2 absent
    do_tick(4);
    check_all("R4 R9 tick1");
    // R4 long high level still one decrement, falling edge no effect
    do_tick(30);
    check_all("R4 R5 R7 long tick wrap cpu3");
    do_tick(3);
    check_all("R6 sticky cpu3");
    do_tick(3);
    check_all("R5 R6 wrap cpu0");
    do_tick(3);
    check_all("R6 R8 repeat");

    // R8 write clears irq and overflow
    wr_cpu(3, 32'd7);
    check_all("R8 R2 clear cpu3");

    // R10 write lands on the tick update cycle (third edge after rise)
    @(negedge clk);
    tick_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = ofs[0]; csr_wdata = 32'h40;
    @(negedge clk);
    csr_wr = 1'b0;
    tick_in = 1'b0;
    repeat (6) @(negedge clk);
    model_tick(0);
    mdl[0] = 25'h40; exp_irq[0] = 1'b0;
    check_all("R10 write wins");

    // R9 absent CPU never signals
    check("R9 irq2", {31'd0, timer_irq[2]}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule